// File: doc/BRIEF.md
# Periodic Interrupt Prescaler Divider

This block is a free-running binary up-counter, 14 bits wide by default, clocked by the system oscillator. Its carry out of the top bit marks one period of the divider. The overflow sets a sticky event flag, and the flag feeds two separate gated requests. One is an interrupt request and the other is a request to leave a low-power hold state. Each request has its own enable.

Software can issue two commands. The first clears the event flag. The second zeroes only the upper counter bits, which restarts the coarse period while the fine bits keep running. The full counter value is brought out. Two single-cycle tap ticks are also brought out, at 1/1024 and 1/16384 of the clock rate, so that other timers can run from the same chain.

Top module: `prescale_div`

## Requirements
- R1: Reset (`rst_ni` low) forces `count_o` to 0 and forces `flag_o`, `irq_o`, `hold_rel_o`, `tick_lo_o` and `tick_hi_o` to 0.
- R2: With `div_clr_i` low, `count_o` increases by one on every clock edge and wraps from 0x3FFF to 0x0000.
- R3: A wrap from 0x3FFF sets `flag_o` to 1 on the same edge.
- R4: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R5: `hold_rel_o` is 1 exactly when `flag_o` is 1 and `hold_en_i` is 1. The two enables act independently.
- R6: `tick_lo_o` is 1 for exactly the cycles in which bit 9 of `count_o` has just changed from 0 to 1. This gives one pulse per 1024 cycles.
- R7: `tick_hi_o` is 1 for exactly the cycles in which bit 13 of `count_o` has just changed from 0 to 1. This gives one pulse per 16384 cycles.
- R8: Once set, `flag_o` stays at 1 until reset or until an edge with `flag_clr_i` high. Further wraps and the passing of time leave it set.
- R9: On an edge with `div_clr_i` high, bits 13:10 of `count_o` become 0. Bits 9:0 still increment, and their carry into bit 10 is dropped.
- R10: When `flag_clr_i` is high on the same edge as a wrap, the flag is set: the overflow has priority.
- R11: When `div_clr_i` is high while `count_o` is 0x3FFF, the count goes to 0 and no overflow is recorded, so `flag_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_clr_i | input | 1 | Zero the upper four counter bits on this edge |
| flag_clr_i | input | 1 | Clear the event flag on this edge |
| irq_en_i | input | 1 | Interrupt request enable |
| hold_en_i | input | 1 | Hold-release request enable |
| count_o | output | 14 | Current counter value (all stages) |
| flag_o | output | 1 | Sticky overflow event flag |
| irq_o | output | 1 | Interrupt request |
| hold_rel_o | output | 1 | Hold-state release request |
| tick_lo_o | output | 1 | One-cycle pulse at clock/1024 |
| tick_hi_o | output | 1 | One-cycle pulse at clock/16384 |

## Verification
Three pairs of events can land on the same edge: a flag clear with a wrap, an upper-bit clear with a wrap, and an upper-bit clear in the middle of a count. The bench drives the count to 0x3FFF and asserts `flag_clr_i` on that edge, and it expects the flag to remain 1. It then drives the count to 0x3FFF again, this time with `div_clr_i`, and expects a zero count with the flag unchanged. A reference model stepped on the same edges judges each cycle's outputs, and the tap ticks are judged from the observed transitions of the count bits.

// File: rtl/prescale_div_pkg.sv
package prescale_div_pkg;
  localparam int unsigned CNT_W  = 14;  // counter stages
  localparam int unsigned HI_CLR = 4;   // upper stages zeroed by divider clear
  localparam int unsigned TAP_LO = 10;  // stage giving clock/1024
  localparam int unsigned TAP_HI = 14;  // stage giving clock/16384
endpackage

// File: rtl/prescale_div_cnt.sv
module prescale_div_cnt #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned HI_CLR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             ovf_o
);
  localparam int unsigned LO_W = CNT_W - HI_CLR;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LO_W-1:0]  lo_inc;

  assign lo_inc = cnt_q[LO_W-1:0] + LO_W'(1);

  always_comb begin
    if (div_clr_i) cnt_d = {{HI_CLR{1'b0}}, lo_inc};
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // overflow is the carry out of the top stage; a clear suppresses it
  assign ovf_o     = (&cnt_q) && !div_clr_i;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_clr_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clr_i |=> cnt_q[CNT_W-1:LO_W] == '0);
  a_r9_lower_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clr_i |=> cnt_q[LO_W-1:0] == LO_W'($past(cnt_q[LO_W-1:0]) + LO_W'(1)));
endmodule

// File: rtl/prescale_div_tap.sv
module prescale_div_tap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_now_i,
  input  logic bit_nxt_i,
  output logic tick_o
);
  logic tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= bit_nxt_i & ~bit_now_i;
  end

  assign tick_o = tick_q;

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
endmodule

// File: rtl/prescale_div_flag.sv
module prescale_div_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (ovf_i) flag_q <= 1'b1;   // overflow beats clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r3_set_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_q);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ovf_i) |=> !flag_q);
endmodule

// File: rtl/prescale_div.sv
module prescale_div
  import prescale_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_clr_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic             hold_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             hold_rel_o,
  output logic             tick_lo_o,
  output logic             tick_hi_o
);
  localparam int unsigned N_TAP = 2;
  localparam int unsigned TAP_STAGE [N_TAP] = '{TAP_LO, TAP_HI};

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             ovf, flag;
  logic [N_TAP-1:0] ticks;

  prescale_div_cnt #(.CNT_W(CNT_W), .HI_CLR(HI_CLR)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_clr_i(div_clr_i),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .ovf_o(ovf)
  );

  for (genvar t = 0; t < N_TAP; t++) begin : g_tap
    prescale_div_tap u_tap (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .bit_now_i(cnt[TAP_STAGE[t]-1]),
      .bit_nxt_i(cnt_nxt[TAP_STAGE[t]-1]),
      .tick_o(ticks[t])
    );
  end

  prescale_div_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovf_i(ovf), .clr_i(flag_clr_i), .flag_o(flag)
  );

  assign count_o    = cnt;
  assign flag_o     = flag;
  assign irq_o      = flag & irq_en_i;
  assign hold_rel_o = flag & hold_en_i;
  assign tick_lo_o  = ticks[0];
  assign tick_hi_o  = ticks[1];

  a_r6_tick_lo_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_lo_o |-> cnt[TAP_LO-1]);
  a_r7_tick_hi_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_hi_o |-> cnt[TAP_HI-1]);
  a_r4_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);
  a_r5_hold_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rel_o |-> flag);
endmodule

// File: tb/prescale_div_bench.sv
`timescale 1ns/1ps
module prescale_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_clr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0, hold_en = 1'b0;
  logic [13:0] count;
  logic        flag, irq, hold_rel, tick_lo, tick_hi;

  int checks = 0, failures = 0;

  // reference model
  logic [13:0] m_cnt;
  logic        m_flag;
  logic        prev_b9, prev_b13;
  int          n_lo, n_hi;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  prescale_div u_prescale_div (
    .clk_i(clk), .rst_ni(rst_n), .div_clr_i(div_clr), .flag_clr_i(flag_clr),
    .irq_en_i(irq_en), .hold_en_i(hold_en), .count_o(count), .flag_o(flag),
    .irq_o(irq), .hold_rel_o(hold_rel), .tick_lo_o(tick_lo), .tick_hi_o(tick_hi)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_flag <= 1'b0;
    end else begin
      logic wrap;
      wrap = (m_cnt == 14'h3FFF) && !div_clr;
      if (div_clr) m_cnt <= {4'h0, 10'(m_cnt[9:0] + 10'd1)};
      else         m_cnt <= m_cnt + 14'd1;
      if (wrap) m_flag <= 1'b1;
      else if (flag_clr) m_flag <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance n cycles, compare every cycle at negedge; one check per call
  task automatic run(input int n, input string req);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (count !== m_cnt || flag !== m_flag ||
          irq !== (m_flag & irq_en) || hold_rel !== (m_flag & hold_en) ||
          tick_lo !== (count[9] & ~prev_b9) || tick_hi !== (count[13] & ~prev_b13)) begin
        if (bad == 0) begin
          a = {count, 12'h0, flag, irq, hold_rel, tick_lo, tick_hi};
          e = {m_cnt, 12'h0, m_flag, m_flag & irq_en, m_flag & hold_en,
               count[9] & ~prev_b9, count[13] & ~prev_b13};
        end
        bad++;
      end
      n_lo += int'(tick_lo); n_hi += int'(tick_hi);
      prev_b9 = count[9]; prev_b13 = count[13];
    end
    check(req, a, e);
  endtask

  task automatic run_to(input logic [13:0] target, input string req);
    int n;
    n = int'(target - m_cnt) & 16'h3FFF;
    if (n > 0) run(n, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #12;
    check("R1 count", 32'(count), 0);
    check("R1 outputs", {flag, irq, hold_rel, tick_lo, tick_hi}, 0);
    prev_b9 = 1'b0; prev_b13 = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_count;
    run(100, "R2 increment");
    check("R2 value after 100", 32'(count), 100);
  endtask

  task automatic t_taps_wrap;
    n_lo = 0; n_hi = 0;
    run_to(14'h3FFF, "R6 R7 taps to top");
    check("R3 flag before wrap", 32'(flag), 0);
    run(1, "R3 wrap");
    check("R2 wrap to zero", 32'(count), 0);
    check("R3 flag set on wrap", 32'(flag), 1);
    check("R6 tick_lo count", 32'(n_lo), 16);
    check("R7 tick_hi count", 32'(n_hi), 1);
  endtask

  task automatic t_enables;
    irq_en = 1'b0; hold_en = 1'b0; #0.1;
    check("R4 R5 none enabled", {irq, hold_rel}, 0);
    irq_en = 1'b1; #0.1;
    check("R4 irq only", {irq, hold_rel}, 2'b10);
    irq_en = 1'b0; hold_en = 1'b1; #0.1;
    check("R5 hold only", {irq, hold_rel}, 2'b01);
    irq_en = 1'b1; #0.1;
    check("R4 R5 both", {irq, hold_rel}, 2'b11);
    run(3000, "R8 sticky with enables");
    check("R8 still set", 32'(flag), 1);
  endtask

  task automatic t_flag_clear;
    flag_clr = 1'b1; run(1, "R8 clear"); flag_clr = 1'b0;
    check("R8 cleared", 32'(flag), 0);
    check("R4 irq drops", {irq, hold_rel}, 0);
  endtask

  task automatic t_div_clr;
    run_to(14'h2ABC, "R9 approach");
    div_clr = 1'b1; run(1, "R9 clear"); div_clr = 1'b0;
    check("R9 upper zero lower runs", 32'(count), 32'h02BD);
    run(5, "R9 after clear");
    check("R9 continue", 32'(count), 32'h02C2);
  endtask

  task automatic t_collide;
    run_to(14'h3FFF, "R10 approach");
    flag_clr = 1'b1; run(1, "R10 same edge"); flag_clr = 1'b0;
    check("R10 overflow wins", 32'(flag), 1);
    flag_clr = 1'b1; run(1, "R10 clear"); flag_clr = 1'b0;
    check("R10 cleared later", 32'(flag), 0);
    run_to(14'h3FFF, "R11 approach");
    div_clr = 1'b1; run(1, "R11 clear at top"); div_clr = 1'b0;
    check("R11 count zero", 32'(count), 0);
    check("R11 no overflow", 32'(flag), 0);
  endtask

  initial begin
    n_lo = 0; n_hi = 0;
    t_reset();
    t_count();
    t_taps_wrap();
    t_enables();
    t_flag_clear();
    t_div_clr();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule